// File: doc/BRIEF.md
# I2C Control-Register Slave

This block connects a bank of twelve 8-bit control registers to an I2C bus as a slave device. An external bus controller writes the registers by naming a starting register index and then sending one or more data bytes. The index steps forward by one after each accepted byte, so a single transaction can fill a run of neighbouring registers. The same device address with the read bit set returns a status byte that the surrounding logic supplies on a parallel input. The block never starts a transfer, never holds the clock low and never arbitrates for the bus.

SCL and SDA are sampled in the system clock domain through two-flop synchronizers. START and STOP are detected on the synchronized lines. Incoming bits are shifted MSB first on rising SCL edges under a bit counter. The block pulls SDA low through an open-drain enable output when it acknowledges a byte or sends a zero bit. The register contents are always visible on a flat parallel bus.

Top module: `i2c_ctlreg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 7'h12, which gives 8'h24 for a write and 8'h25 for a read. For any other address byte it never pulls SDA low, and it stores nothing until the next START or STOP.
- R2: A write consists of the address byte 8'h24, an index byte and a data byte. The block acknowledges each of these bytes by holding SDA low through the ninth SCL high phase, and the data byte lands in the register selected by the index.
- R3: A START (SDA falling while SCL is high) clears the bit counter, the shift register and the transaction state at any point. A partly received byte is dropped, and the following transaction is decoded from its first bit.
- R4: After each data byte is stored and acknowledged, the register index steps up by one. Consecutive data bytes in one transaction therefore fill consecutive registers.
- R5: A data byte whose register index is above 8'h0B is neither acknowledged nor stored. The index does not wrap back to 8'h00.
- R6: After address 8'h25 the block sends the flag input MSB first, one bit per SCL low phase. It sends the byte again after each master acknowledge and releases SDA for good after a master not-acknowledge.
- R7: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Register contents change only on an accepted data byte.
- R8: The synchronous active-low reset clears all registers to 8'h00 and releases SDA.
- R9: The block changes its SDA drive only while the synchronized SCL is low, except when a START or STOP clears it.
- R10: Register n appears on regs_o bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| flag_i | input | 8 | Status byte returned on a read |
| regs_o | output | 96 | Control registers, register n at [8n+7:8n] |

## Verification
A wrong phase or a bad bit count shows up at the ports within one byte time. The acknowledge goes missing or appears on the wrong clock, which the bench sees on the ninth SCL pulse, or the target register gets a shifted value, which is visible on regs_o as soon as that acknowledge ends. A bad index shows as a write to a neighbouring register or as a wrapped write to register 0, and that is exposed once the full bank is compared after each transaction. A read path that loses its place returns a rotated flag byte or keeps driving SDA after the not-acknowledge, and the bench observes sda_oe directly to catch the latter.

// File: rtl/i2c_ctlreg_pkg.sv
// Shared definitions for the I2C control-register slave.
// Assumes 8-bit bytes on the bus; everything else is set per instance.
package i2c_ctlreg_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    // Transaction phase of the slave controller.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_SUB   = 3'd2,
        PH_WDATA = 3'd3,
        PH_READ  = 3'd4,
        PH_SKIP  = 3'd5
    } phase_t;
endpackage

// File: rtl/i2c_ctlreg_linecond.sv
// Bus line conditioner: synchronizes SCL and SDA into clk with two flops
// each, then gives levels, SCL edges and START/STOP events.
// Assumes clk is at least 8x faster than SCL so that every edge is seen.
module i2c_ctlreg_linecond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] meta;
    logic [NLINES-1:0] stab;
    logic [NLINES-1:0] prev;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] fall;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // Two-flop synchronizer plus history flop; idle bus reads high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[g] <= 1'b1;
                stab[g] <= 1'b1;
                prev[g] <= 1'b1;
            end else begin
                meta[g] <= raw[g];
                stab[g] <= meta[g];
                prev[g] <= stab[g];
            end
        end
        assign rise[g] = stab[g] & ~prev[g];
        assign fall[g] = ~stab[g] & prev[g];
    end

    // Levels and events presented to the controller.
    always_comb begin
        scl_lvl   = stab[0];
        sda_lvl   = stab[1];
        scl_rise  = rise[0];
        scl_fall  = fall[0];
        start_det = fall[1] & stab[0] & prev[0];
        stop_det  = rise[1] & stab[0] & prev[0];
    end
endmodule

// File: rtl/i2c_ctlreg_regbank.sv
// Bank of NREG byte registers with one write port; all reset to zero.
// Assumes the caller only presents in-range indices with wr_en.
module i2c_ctlreg_regbank #(
    parameter int NREG = 12,
    parameter int IDX_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [i2c_ctlreg_pkg::BYTE_W-1:0] wr_data,
    output logic [NREG*i2c_ctlreg_pkg::BYTE_W-1:0] regs_o
);
    import i2c_ctlreg_pkg::*;

    for (genvar n = 0; n < NREG; n++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(n));
        // One register: load on a matching write, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[n*BYTE_W +: BYTE_W] <= '0;
            else if (hit)
                regs_o[n*BYTE_W +: BYTE_W] <= wr_data;
        end
    end
endmodule

// File: rtl/i2c_ctlreg_ctrl.sv
// Slave transaction controller: bit counter, receive shift register,
// address/read latch, register index latch, transmit register and the
// open-drain SDA enable. Acts only on edges from the line conditioner.
// Assumes one event at most per clk cycle (guaranteed by the clock ratio).
module i2c_ctlreg_ctrl #(
    parameter int          NREG     = 12,
    parameter int          IDX_W    = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sda_lvl,
    input  logic                              scl_rise,
    input  logic                              scl_fall,
    input  logic                              start_det,
    input  logic                              stop_det,
    input  logic [i2c_ctlreg_pkg::BYTE_W-1:0] flag_i,
    output logic                              sda_oe,
    output logic                              wr_en,
    output logic [IDX_W-1:0]                  wr_idx,
    output logic [i2c_ctlreg_pkg::BYTE_W-1:0] wr_data,
    output logic [i2c_ctlreg_pkg::CNT_W-1:0]  bit_cnt_o,
    output i2c_ctlreg_pkg::phase_t            phase_o
);
    import i2c_ctlreg_pkg::*;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(NREG);

    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [IDX_W-1:0]  idx;
    logic              is_read;
    logic              in_ack;
    logic              m_nack;

    assign wr_idx    = idx;
    assign wr_data   = rx_sr;
    assign bit_cnt_o = bit_cnt;
    assign phase_o   = phase;

    // Main sequencer: bus events drive shifting, acknowledge and writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            idx     <= '0;
            is_read <= 1'b0;
            in_ack  <= 1'b0;
            m_nack  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                rx_sr   <= '0;
                in_ack  <= 1'b0;
                m_nack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_SUB, PH_WDATA: begin
                        if (scl_rise && bit_cnt < LAST_BIT) begin
                            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            if (!in_ack) begin
                                // End of the eighth clock: judge the byte.
                                in_ack <= 1'b1;
                                case (phase)
                                    PH_ADDR: begin
                                        if (rx_sr[BYTE_W-1:1] == DEV_ADDR) begin
                                            sda_oe  <= 1'b1;
                                            is_read <= rx_sr[0];
                                        end else begin
                                            phase <= PH_SKIP;
                                        end
                                    end
                                    PH_SUB: begin
                                        idx    <= rx_sr;
                                        sda_oe <= 1'b1;
                                    end
                                    default: begin
                                        if (idx < TOP_IDX) begin
                                            sda_oe <= 1'b1;
                                            wr_en  <= 1'b1;
                                        end else begin
                                            phase <= PH_SKIP;
                                        end
                                    end
                                endcase
                            end else begin
                                // End of the ninth clock: release and advance.
                                in_ack  <= 1'b0;
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                case (phase)
                                    PH_ADDR: begin
                                        if (is_read) begin
                                            phase  <= PH_READ;
                                            tx_sr  <= flag_i;
                                            sda_oe <= ~flag_i[BYTE_W-1];
                                        end else begin
                                            phase <= PH_SUB;
                                        end
                                    end
                                    PH_SUB:  phase <= PH_WDATA;
                                    default: idx <= idx + 1'b1;
                                endcase
                            end
                        end
                    end
                    PH_READ: begin
                        if (scl_rise) begin
                            if (bit_cnt < LAST_BIT)
                                bit_cnt <= bit_cnt + 1'b1;
                            else
                                m_nack <= sda_lvl;
                        end else if (scl_fall) begin
                            if (bit_cnt != '0 && bit_cnt < LAST_BIT) begin
                                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sr[BYTE_W-2];
                            end else if (bit_cnt == LAST_BIT && !in_ack) begin
                                in_ack <= 1'b1;
                                sda_oe <= 1'b0;
                            end else if (in_ack) begin
                                in_ack  <= 1'b0;
                                bit_cnt <= '0;
                                if (m_nack) begin
                                    phase <= PH_SKIP;
                                end else begin
                                    tx_sr  <= flag_i;
                                    sda_oe <= ~flag_i[BYTE_W-1];
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_ctlreg_slave.sv
// Top of the I2C control-register slave: line conditioner, controller and
// register bank. Assumes an external open-drain pad driven low by sda_oe.
module i2c_ctlreg_slave #(
    parameter int         NREG     = 12,
    parameter logic [6:0] DEV_ADDR = 7'h12
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   scl_i,
    input  logic                                   sda_i,
    output logic                                   sda_oe,
    input  logic [i2c_ctlreg_pkg::BYTE_W-1:0]      flag_i,
    output logic [NREG*i2c_ctlreg_pkg::BYTE_W-1:0] regs_o
);
    import i2c_ctlreg_pkg::*;

    localparam int IDX_W = BYTE_W;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic              start_det, stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [CNT_W-1:0]  bit_cnt;
    phase_t            phase;

    i2c_ctlreg_linecond u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ctlreg_ctrl #(
        .NREG     (NREG),
        .IDX_W    (IDX_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .flag_i    (flag_i),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .bit_cnt_o (bit_cnt),
        .phase_o   (phase)
    );

    i2c_ctlreg_regbank #(
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs_o)
    );
endmodule

// File: rtl/i2c_ctlreg_checker.sv
// Protocol checker bound to the slave top; observes only, drives nothing.
module i2c_ctlreg_checker #(
    parameter int NREG = 12
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   scl_lvl,
    input logic                                   start_det,
    input logic                                   stop_det,
    input logic                                   sda_oe,
    input logic                                   wr_en,
    input logic [7:0]                             wr_idx,
    input logic [3:0]                             bit_cnt,
    input i2c_ctlreg_pkg::phase_t                 phase,
    input logic [NREG*i2c_ctlreg_pkg::BYTE_W-1:0] regs_o
);
    import i2c_ctlreg_pkg::*;

    assert_quiet_when_ignoring_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP || phase == PH_IDLE) |-> !sda_oe);

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bit_cnt == 4'd0 && !sda_oe && phase == PH_ADDR));

    assert_write_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < 8'(NREG)));

    assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (phase == PH_IDLE && !sda_oe));

    assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    assert_drive_on_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_lvl));
endmodule

bind i2c_ctlreg_slave i2c_ctlreg_checker #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .bit_cnt   (bit_cnt),
    .phase     (phase),
    .regs_o    (regs_o)
);

// File: tb/i2c_ctlreg_slave_tb.sv
// Bench: drives the bus as a controller, models the registers from the
// requirements and compares at the ports.
module i2c_ctlreg_slave_tb_top;
    localparam int NREG = 12;
    localparam int Q    = 6;   // clk cycles per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [7:0] flag = 8'h00;
    logic [NREG*8-1:0] regs;
    logic [7:0] model [NREG];
    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_bus = sda_m & ~sda_oe;

    i2c_ctlreg_slave #(.NREG(NREG)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .flag_i (flag),
        .regs_o (regs)
    );

    // {expected data ack, index, data}
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 8'h00, 8'hA5},
        {1'b1, 8'h0B, 8'h3C},
        {1'b1, 8'h05, 8'hFF},
        {1'b0, 8'h0C, 8'h77},
        {1'b1, 8'h07, 8'h01},
        {1'b0, 8'hFF, 8'h55}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = (sda_bus == 1'b0);
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_bus;
            wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic chk_bank(input string tag);
        for (int n = 0; n < NREG; n++) chk(tag, regs[n*8 +: 8], model[n]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        for (int n = 0; n < NREG; n++) model[n] = 8'h00;
        wq(5);
        // R8: reset state
        chk("R8 sda_oe", sda_oe, 1'b0);
        chk("R8 regs", regs, '0);
        rst_n = 1'b1;
        wq(4);

        // Table walk: single-register writes (R1, R2, R5, R10)
        for (int v = 0; v < 6; v++) begin
            bus_start();
            send_byte(8'h24, ack);
            chk("R1 write addr ack", ack, 1'b1);
            send_byte(VEC[v][15:8], ack);
            chk("R2 index ack", ack, 1'b1);
            send_byte(VEC[v][7:0], ack);
            chk("R2/R5 data ack", ack, VEC[v][16]);
            bus_stop();
            if (VEC[v][16]) model[VEC[v][15:8]] = VEC[v][7:0];
            chk_bank("R2/R10 bank");
        end

        // R4 and R5: auto-increment run past the last register, no wrap
        bus_start();
        send_byte(8'h24, ack);
        send_byte(8'h09, ack);
        send_byte(8'h11, ack); chk("R4 ack 9", ack, 1'b1);
        send_byte(8'h22, ack); chk("R4 ack 10", ack, 1'b1);
        send_byte(8'h33, ack); chk("R4 ack 11", ack, 1'b1);
        send_byte(8'h44, ack); chk("R5 ack past end", ack, 1'b0);
        bus_stop();
        model[9] = 8'h11; model[10] = 8'h22; model[11] = 8'h33;
        chk_bank("R4/R5 bank");

        // R1: foreign address is ignored
        bus_start();
        send_byte(8'h26, ack); chk("R1 foreign addr nack", ack, 1'b0);
        send_byte(8'h00, ack); chk("R1 ignored index", ack, 1'b0);
        send_byte(8'hEE, ack); chk("R1 ignored data", ack, 1'b0);
        bus_stop();
        chk_bank("R1 bank unchanged");

        // R3: START in the middle of a data byte
        bus_start();
        send_byte(8'h24, ack);
        send_byte(8'h03, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        chk("R3 partial byte not stored", regs[3*8 +: 8], model[3]);
        bus_start();
        send_byte(8'h24, ack); chk("R3 restart addr ack", ack, 1'b1);
        send_byte(8'h03, ack);
        send_byte(8'h5A, ack); chk("R3 restart data ack", ack, 1'b1);
        bus_stop();
        model[3] = 8'h5A;
        chk_bank("R3 bank");

        // R6: flag read, master acks once then nacks
        flag = 8'hC3;
        bus_start();
        send_byte(8'h25, ack); chk("R1 read addr ack", ack, 1'b1);
        recv_byte(1'b1, rb); chk("R6 first flag byte", rb, 8'hC3);
        recv_byte(1'b0, rb); chk("R6 second flag byte", rb, 8'hC3);
        wq(Q);
        chk("R6 released after nack", sda_oe, 1'b0);
        bus_stop();

        // R7: STOP idles with SDA free and registers held
        wq(4);
        chk("R7 sda released", sda_oe, 1'b0);
        chk_bank("R7 bank held");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule